// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block takes bytes from a MAC-side producer over a valid/ready handshake with an end-of-frame marker. It drives them onto a two-bit transmit bus with a frame-enable strobe, timed from one continuous 50 MHz reference clock. Each byte leaves as four two-bit symbols, least significant pair first. The enable stays high without a break from the first symbol of a frame to the last. The producer supplies the whole frame as bytes, preamble included. This block adds no framing or checksum.

A static speed input selects the rate. At 100 Mbit/s the bus advances one symbol per clock. At 10 Mbit/s a free-running divide-by-ten prescaler gives a one-clock advance pulse, and each symbol is held for ten clocks. The prescaler is never realigned to a frame, so the start latency of a frame varies. The speed in use is captured only while the bus is idle. If the producer fails to supply a byte when the bus needs one, the frame is cut short and a sticky error flag is raised.

Top module: `rmii_tx_serializer`

## Requirements
- R1: After reset, and whenever `tx_en` is low, `txd` reads 00; `tx_en` and `underrun_err` are low after reset.
- R2: A byte B is sent as four symbols in the order B[1:0], B[3:2], B[5:4], B[7:6]; within each symbol `txd[0]` carries the lower-numbered (earlier) bit.
- R3: In fast mode (`slow_mode`=0) the bus advances one symbol every clock, and bytes accepted back to back keep `tx_en` high with no gap, so an N-byte frame keeps `tx_en` high for exactly 4N clocks in one run.
- R4: In slow mode (`slow_mode`=1) each symbol is held stable for exactly DIV (default 10) clocks. Advances occur only on a free-running prescaler pulse that has one clock high every DIV clocks and is not aligned to frames.
- R5: `in_ready` is high only on an advance slot, either while idle or while the last symbol of a byte not marked last is on the bus. Within an N-byte frame it is therefore seen high on exactly N-1 clocks while `tx_en` is high.
- R6: `tx_en` falls, and `txd` returns to 00, on the first advance slot after the final symbol of the byte accepted with `in_last`=1.
- R7: `slow_mode` is sampled only while `tx_en` is low. A change made mid-frame does not alter the pacing of that frame and takes effect from the next frame.
- R8: If `in_valid` is low on the slot where a frame's next byte is needed, the frame ends at that slot and `underrun_err` goes high. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock, rising edge only |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mode | input | 1 | 1 selects 10 Mbit/s pacing, 0 selects 100 Mbit/s |
| in_data | input | 8 | Byte offered by the producer |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | The offered byte ends the frame |
| in_ready | output | 1 | Byte is taken on this clock when `in_valid` is high |
| txd | output | 2 | Transmit symbol; bit 0 is the earlier bit |
| tx_en | output | 1 | High for every clock that carries frame data |
| underrun_err | output | 1 | Sticky flag for a frame cut short by missing data |

## Verification
The bench sends frames of several lengths and byte patterns at both speeds and rebuilds the expected symbol stream from the bytes. A design with swapped or misordered symbols, or a gap between bytes, fails the symbol-by-symbol comparison and the single-run count of enable. In slow mode every symbol must occupy exactly ten samples, so a prescaler of the wrong period, or an advance that ignores it, changes the sample count. The bench flips the speed input in mid-frame and expects the old pacing until the frame ends. It also starves the handshake to check that the frame is cut short and that the error flag stays set through a later good frame until reset.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;
  typedef logic [1:0] dibit_t;

  // Symbol number idx (0 goes first) of a byte.
  function automatic dibit_t dibit_of(input logic [7:0] b, input logic [1:0] idx);
    return b[{idx, 1'b0} +: 2];
  endfunction

  // Symbols per byte minus one: the index of the final symbol.
  localparam logic [1:0] LAST_SYM = 2'd3;
endpackage

// File: rtl/rmii_tx_prescaler.sv
module rmii_tx_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  // Free running: never cleared by frame activity.
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (cnt_q == TOP) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == TOP);
endmodule

// File: rtl/rmii_tx_speed_latch.sv
module rmii_tx_speed_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic slow_req,
  output logic slow_q
);
  // The requested speed passes through only between frames.
  always_ff @(posedge clk) begin
    if (!rst_n)     slow_q <= 1'b0;
    else if (!busy) slow_q <= slow_req;
  end
endmodule

// File: rtl/rmii_tx_lane.sv
module rmii_tx_lane
  import rmii_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output dibit_t     txd,
  output logic       tx_en,
  output logic       underrun_err
);
  logic       act_q;
  logic [1:0] sym_q;
  logic [7:0] byte_q;
  logic       last_q;
  logic       err_q;

  logic on_final_sym;
  logic need_byte;

  assign on_final_sym = act_q && (sym_q == LAST_SYM);
  assign need_byte    = !act_q || (on_final_sym && !last_q);
  assign in_ready     = adv && need_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sym_q  <= '0;
      byte_q <= '0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (adv) begin
      if (need_byte) begin
        if (in_valid) begin
          act_q  <= 1'b1;
          sym_q  <= '0;
          byte_q <= in_data;
          last_q <= in_last;
        end else if (act_q) begin
          act_q <= 1'b0;   // underrun (R8)
          err_q <= 1'b1;
        end
      end else if (on_final_sym) begin
        act_q <= 1'b0;     // final symbol of last byte done (R6)
      end else if (act_q) begin
        sym_q <= sym_q + 1'b1;
      end
    end
  end

  assign txd          = act_q ? dibit_of(byte_q, sym_q) : 2'b00;
  assign tx_en        = act_q;
  assign underrun_err = err_q;
endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer #(
  parameter int DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_mode,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [1:0] txd,
  output logic       tx_en,
  output logic       underrun_err
);
  logic tick;
  logic frame_slow;
  logic adv;

  rmii_tx_prescaler #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  rmii_tx_speed_latch u_spd (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (tx_en),
    .slow_req(slow_mode),
    .slow_q  (frame_slow)
  );

  assign adv = frame_slow ? tick : 1'b1;

  rmii_tx_lane u_lane (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (adv),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .txd         (txd),
    .tx_en       (tx_en),
    .underrun_err(underrun_err)
  );
endmodule

// File: rtl/rmii_tx_serializer_chk.sv
module rmii_tx_serializer_chk #(
  parameter int DIV = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] txd,
  input logic       tx_en,
  input logic       in_ready,
  input logic       underrun_err,
  input logic       tick,
  input logic       adv,
  input logic       frame_slow
);
  int  gap;
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == 2'b00);

  a_r4_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> gap == DIV - 1);

  a_r4_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$past(adv)) |-> $stable(txd));

  a_r5_ready_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> adv);

  a_r6_end_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> $past(adv));

  a_r7_speed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en)) |-> $stable(frame_slow));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_err |=> underrun_err);
endmodule

bind rmii_tx_serializer rmii_tx_serializer_chk #(.DIV(DIV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txd         (txd),
  .tx_en       (tx_en),
  .in_ready    (in_ready),
  .underrun_err(underrun_err),
  .tick        (tick),
  .adv         (adv),
  .frame_slow  (frame_slow)
);

// File: tb/sim_rmii_tx_serializer.sv
module sim_rmii_tx_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_mode = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [1:0] txd;
  logic       tx_en;
  logic       underrun_err;

  always #2 clk = ~clk;

  rmii_tx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .txd(txd), .tx_en(tx_en),
    .underrun_err(underrun_err)
  );

  // {slow, last, data}
  localparam logic [9:0] VEC [12] = '{
    {1'b0, 1'b0, 8'h55}, {1'b0, 1'b0, 8'hD5}, {1'b0, 1'b1, 8'hA3},
    {1'b1, 1'b1, 8'h1E},
    {1'b0, 1'b0, 8'hFF}, {1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 8'hC6},
    {1'b0, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'h81}, {1'b1, 1'b1, 8'h7E},
    {1'b0, 1'b1, 8'h01}, {1'b0, 1'b1, 8'h9B}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] cap [0:1023];
  int   ncap = 0, nrise = 0, nready = 0;
  logic prev_en = 1'b0;
  logic [7:0] fb [0:7];
  int   fn = 0;

  always @(negedge clk) begin
    if (tx_en) begin
      if (ncap < 1024) cap[ncap] = txd;
      ncap++;
      if (!prev_en) nrise++;
      if (in_ready) nready++;
    end
    prev_en = tx_en;
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_cap();
    ncap = 0; nrise = 0; nready = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (tx_en) @(negedge clk);
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    slow_mode = m;
    repeat (2) @(negedge clk);
  endtask

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic push(input logic [7:0] d, input bit l);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic check_frame(input string tag, input bit slow);
    int mult, bad, first_bad_act, first_bad_exp;
    mult = slow ? 10 : 1;
    bad = 0; first_bad_act = 0; first_bad_exp = 0;
    for (int k = 0; k < 4 * fn * mult && k < 1024; k++) begin
      int s;
      int e;
      s = k / mult;
      e = (fb[s / 4] >> (2 * (s % 4))) & 3;
      if (int'(cap[k]) != e) begin
        if (bad == 0) begin first_bad_act = int'(cap[k]); first_bad_exp = e; end
        bad++;
      end
    end
    check({tag, " R2 symbol order"}, bad == 0, first_bad_act, first_bad_exp);
    if (slow)
      check({tag, " R4 ten-clock hold length"}, ncap == 40 * fn, ncap, 40 * fn);
    else
      check({tag, " R3 one symbol per clock"}, ncap == 4 * fn, ncap, 4 * fn);
    check({tag, " R3 single enable run"}, nrise == 1, nrise, 1);
    check({tag, " R5 ready pulses in frame"}, nready == fn - 1, nready, fn - 1);
    check({tag, " R6 txd idle after end"}, txd == 2'b00, int'(txd), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset tx_en", tx_en == 1'b0, int'(tx_en), 0);
    check("R1 reset txd", txd == 2'b00, int'(txd), 0);
    check("R1 reset err", underrun_err == 1'b0, int'(underrun_err), 0);

    // Table walk: frames at both speeds.
    fn = 0;
    for (int i = 0; i < 12; i++) begin
      logic m, l;
      logic [7:0] d;
      {m, l, d} = VEC[i];
      if (fn == 0) begin
        wait_idle();
        set_mode(m);
        clear_cap();
      end
      fb[fn] = d;
      fn++;
      push(d, l);
      if (l) begin
        wait_idle();
        check_frame($sformatf("vec%0d", i), m);
        fn = 0;
      end
    end

    // R7: speed change mid-frame is held off until the frame ends.
    set_mode(1'b0);
    clear_cap();
    push(8'h12, 1'b0);
    slow_mode = 1'b1;
    push(8'h34, 1'b0);
    push(8'h56, 1'b0);
    push(8'h78, 1'b1);
    wait_idle();
    check("R7 mid-frame change ignored", ncap == 16, ncap, 16);
    repeat (2) @(negedge clk);
    clear_cap();
    push(8'h5A, 1'b1);
    wait_idle();
    check("R7 new speed at next frame", ncap == 40, ncap, 40);

    // R8: underrun ends the frame and sets a sticky flag.
    set_mode(1'b0);
    check("R8 flag clear before underrun", underrun_err == 1'b0, int'(underrun_err), 0);
    clear_cap();
    push(8'hA5, 1'b0);
    wait_idle();
    check("R8 frame cut after one byte", ncap == 4, ncap, 4);
    check("R8 flag set", underrun_err == 1'b1, int'(underrun_err), 1);
    clear_cap();
    push(8'h3C, 1'b1);
    wait_idle();
    check("R8 flag sticky over good frame", underrun_err == 1'b1, int'(underrun_err), 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 R1 reset clears flag", underrun_err == 1'b0, int'(underrun_err), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule